// File: doc/BRIEF.md
# Write Operation Status Generator

This block builds the word a host sees when it reads the device while an internal program or erase runs. Each read captures one word. During an active operation the word is made of status bits: a polling bit, a toggle bit that flips on every read, an error flag, an erase-timer flag, and a second toggle bit. The second toggle bit flips only for reads that land in sectors chosen for erase. A host can use it to find out which sectors take part in the erase. When the block is idle, and while erase is suspended and the read falls outside the chosen sectors, the read returns the array data presented on a passthrough input. A ready/busy output goes low while an operation actively runs.

The inputs are the operation control state: the operation type, busy, suspended, the chosen-sector bitmap, and the timer and error flags. They come from the embedded controller, which is outside this block. A rising edge on the read strobe marks one host read, whichever enable gated it. The word is registered on the clock edge that sees that rise and stays unchanged until the next rise.

Top module: `wos_status_gen`

## Requirements
- R1: While rst_ni is low, status_o is all zeros and both toggle bits clear to 0.
- R2: ry_by_o is 0 when busy_i is 1 and susp_i is 0, and it is 1 otherwise.
- R3: A read during an active program (op_i = 0, busy_i = 1, susp_i = 0) gives bit 7 equal to the inverse of tgt_bit_i. In that word bit 3 is 0, and bits 0, 1, 4 and 8 and up are 0.
- R4: A read during an active erase (op_i = 1) gives bit 7 = 0 and bit 3 equal to tmo_expired_i. Bits 0, 1, 4 and 8 and up are 0.
- R5: Bit 6 inverts on each read during an active operation. It does not change on other reads or while the strobe stays high.
- R6: Bit 2 inverts only on a read with op_i = 1 and busy_i = 1 whose rd_sector_i indexes a set bit of sel_map_i. This holds whether or not the erase is suspended. A sector index at or above NSEC counts as not chosen.
- R7: Bit 3 follows tmo_expired_i in every active-erase read, and it reads 0 in every program read.
- R8: Bit 5 equals exceed_i in every active-operation read.
- R9: A read with busy_i = 0 returns array_data_i unchanged. So does a suspended read whose sector is not chosen.
- R10: status_o changes only in the cycle after a clock edge that samples rd_strobe_i at 1, where the previous sample was 0. It holds its value at all other times.
- R11: A suspended read in a chosen sector gives bit 7 = 1, bit 6 unchanged, bit 2 as in R6, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 1 | Operation type: 0 program, 1 erase |
| busy_i | input | 1 | An embedded operation is in progress |
| susp_i | input | 1 | The erase is suspended |
| sel_map_i | input | NSEC | Sectors chosen for erase, one bit per sector |
| rd_sector_i | input | SW | Sector index of the read address |
| rd_strobe_i | input | 1 | Read strobe; each rising edge is one read |
| tgt_bit_i | input | 1 | Bit 7 of the data being programmed |
| tmo_expired_i | input | 1 | The erase time-out window has expired |
| exceed_i | input | 1 | The operation has exceeded its time limit |
| array_data_i | input | DW | Array data passthrough |
| status_o | output | DW | Word captured on the last read |
| ry_by_o | output | 1 | Ready (1) or busy (0) |

## Verification
A read rise can fall in the same cycle as a change of busy_i or susp_i. When that happens, the captured word must follow the control state seen at that edge, and the toggle state must advance only if that state allows it. The bench drops busy_i in the same step as a strobe rise. It also raises susp_i together with a rise in a chosen sector. The behavioural model, which reads the same sampled inputs, decides the expected word and the toggle history, and the bench compares against it on every clock.

// File: rtl/wos_pkg.sv
package wos_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_ACTIVE = 2'd1, RD_SUSP = 2'd2} rd_mode_e;
  // bit positions decoded by the host
  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TOG  = 6;
  localparam int unsigned BIT_ERR  = 5;
  localparam int unsigned BIT_TMO  = 3;
  localparam int unsigned BIT_ETOG = 2;
endpackage

// File: rtl/wos_edge.sv
module wos_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strobe_i;
  end
  assign rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/wos_sector_hit.sv
module wos_sector_hit #(
  parameter int unsigned NSEC = 11,
  parameter int unsigned SW   = 4
) (
  input  logic [NSEC-1:0] sel_map_i,
  input  logic [SW-1:0]   sector_i,
  output logic            hit_o
);
  logic [NSEC-1:0] match;
  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    assign match[i] = sel_map_i[i] && (sector_i == SW'(i));
  end
  assign hit_o = |match;
endmodule

// File: rtl/wos_toggle.sv
module wos_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_tog_i,
  input  logic en_etog_i,
  output logic tog_q_o,
  output logic etog_q_o,
  output logic tog_nx_o,
  output logic etog_nx_o
);
  logic tog_q, etog_q;
  assign tog_nx_o  = tog_q ^ en_tog_i;
  assign etog_nx_o = etog_q ^ en_etog_i;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      etog_q <= 1'b0;
    end else begin
      tog_q  <= tog_nx_o;
      etog_q <= etog_nx_o;
    end
  end
  assign tog_q_o  = tog_q;
  assign etog_q_o = etog_q;
endmodule

// File: rtl/wos_compose.sv
module wos_compose
  import wos_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  rd_mode_e        mode_i,
  input  op_e             op_i,
  input  logic            tgt_bit_i,
  input  logic            exceed_i,
  input  logic            tmo_i,
  input  logic            tog_i,
  input  logic            etog_i,
  input  logic [DW-1:0]   array_i,
  output logic [DW-1:0]   word_o
);
  always_comb begin
    word_o = '0;
    unique case (mode_i)
      RD_ACTIVE: begin
        word_o[BIT_POLL] = (op_i == OP_PROG) ? ~tgt_bit_i : 1'b0;
        word_o[BIT_TOG]  = tog_i;
        word_o[BIT_ERR]  = exceed_i;
        word_o[BIT_TMO]  = (op_i == OP_ERASE) & tmo_i;
        word_o[BIT_ETOG] = etog_i;
      end
      RD_SUSP: begin
        word_o[BIT_POLL] = 1'b1;
        word_o[BIT_TOG]  = tog_i;
        word_o[BIT_ETOG] = etog_i;
      end
      default: word_o = array_i;
    endcase
  end
endmodule

// File: rtl/wos_status_gen.sv
module wos_status_gen
  import wos_pkg::*;
#(
  parameter int unsigned NSEC = 11,
  parameter int unsigned DW   = 16,
  localparam int unsigned SW  = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_i,
  input  logic            busy_i,
  input  logic            susp_i,
  input  logic [NSEC-1:0] sel_map_i,
  input  logic [SW-1:0]   rd_sector_i,
  input  logic            rd_strobe_i,
  input  logic            tgt_bit_i,
  input  logic            tmo_expired_i,
  input  logic            exceed_i,
  input  logic [DW-1:0]   array_data_i,
  output logic [DW-1:0]   status_o,
  output logic            ry_by_o
);
  op_e      op;
  rd_mode_e mode;
  logic     rise, hit, active;
  logic     tog6_q, tog2_q, tog6_nx, tog2_nx;
  logic [DW-1:0] word;

  assign op     = op_e'(op_i);
  assign active = busy_i & ~susp_i;

  wos_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(rd_strobe_i), .rise_o(rise)
  );

  wos_sector_hit #(.NSEC(NSEC), .SW(SW)) u_hit (
    .sel_map_i(sel_map_i), .sector_i(rd_sector_i), .hit_o(hit)
  );

  always_comb begin
    if (active)                mode = RD_ACTIVE;
    else if (busy_i && hit)    mode = RD_SUSP;
    else                       mode = RD_ARRAY;
  end

  wos_toggle u_tog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_tog_i (rise & active),
    .en_etog_i(rise & busy_i & hit & (op == OP_ERASE)),
    .tog_q_o  (tog6_q),
    .etog_q_o (tog2_q),
    .tog_nx_o (tog6_nx),
    .etog_nx_o(tog2_nx)
  );

  wos_compose #(.DW(DW)) u_comp (
    .mode_i(mode), .op_i(op), .tgt_bit_i(tgt_bit_i), .exceed_i(exceed_i),
    .tmo_i(tmo_expired_i), .tog_i(tog6_nx), .etog_i(tog2_nx),
    .array_i(array_data_i), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   status_o <= '0;
    else if (rise) status_o <= word;
  end

  assign ry_by_o = ~active;
endmodule

// File: rtl/wos_status_chk.sv
module wos_status_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_i,
  input logic          busy_i,
  input logic          susp_i,
  input logic          rd_strobe_i,
  input logic          tgt_bit_i,
  input logic [DW-1:0] array_data_i,
  input logic [DW-1:0] status_o,
  input logic          tog6_q,
  input logic          tog2_q
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= rd_strobe_i;
  end
  logic rd_rise;
  assign rd_rise = rd_strobe_i & ~prev_q;

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_rise |=> $stable(status_o));
  p_tog_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && busy_i && !susp_i) |=> tog6_q != $past(tog6_q));
  p_tog_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_rise && busy_i && !susp_i) |=> $stable(tog6_q));
  p_poll_prog_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && busy_i && !susp_i && !op_i) |=> status_o[7] == !$past(tgt_bit_i));
  p_idle_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rise && !busy_i) |=> status_o == $past(array_data_i));
  p_etog_prog_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_i |=> $stable(tog2_q));
endmodule

bind wos_status_gen wos_status_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .busy_i(busy_i),
  .susp_i(susp_i), .rd_strobe_i(rd_strobe_i), .tgt_bit_i(tgt_bit_i),
  .array_data_i(array_data_i), .status_o(status_o),
  .tog6_q(tog6_q), .tog2_q(tog2_q)
);

// File: tb/tb_wos_status_gen.sv
module tb_wos_status_gen;
  localparam int NSEC = 11;
  localparam int DW   = 16;
  localparam int SW   = $clog2(NSEC);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic op = 0, busy = 0, susp = 0, strobe = 0, tgt = 0, tmo = 0, exc = 0;
  logic [NSEC-1:0] sel = '0;
  logic [SW-1:0]   sec = '0;
  logic [DW-1:0]   arr = '0;
  logic [DW-1:0]   status;
  logic            ry;

  always #5 clk = ~clk;

  wos_status_gen #(.NSEC(NSEC), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .busy_i(busy), .susp_i(susp),
    .sel_map_i(sel), .rd_sector_i(sec), .rd_strobe_i(strobe), .tgt_bit_i(tgt),
    .tmo_expired_i(tmo), .exceed_i(exc), .array_data_i(arr),
    .status_o(status), .ry_by_o(ry)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int t6 = 0, t2 = 0, prev = 0;
  logic [DW-1:0] exp_w = '0;
  string tag = "R1";

  function automatic bit chosen();
    return (int'(sec) < NSEC) && sel[sec];
  endfunction

  task automatic model();
    bit hit;
    if (!rst_ni) begin
      t6 = 0; t2 = 0; prev = 0; exp_w = '0; tag = "R1";
      return;
    end
    hit = chosen();
    if (strobe && !prev) begin
      if (!busy || (susp && !hit)) begin
        exp_w = arr; tag = "R9";
      end else if (!susp) begin
        t6 ^= 1;
        if (op && hit) t2 ^= 1;
        exp_w = '0;
        exp_w[7] = op ? 1'b0 : ~tgt;
        exp_w[6] = t6[0];
        exp_w[5] = exc;
        exp_w[3] = op ? tmo : 1'b0;
        exp_w[2] = t2[0];
        tag = op ? "R4/R5/R6/R7/R8" : "R3/R5/R6/R7/R8";
      end else begin
        if (op) t2 ^= 1;
        exp_w = '0;
        exp_w[7] = 1'b1;
        exp_w[6] = t6[0];
        exp_w[2] = t2[0];
        tag = "R11/R6";
      end
    end else if (rst_ni) tag = "R10";
    prev = strobe;
  endtask

  task automatic cyc();
    logic exp_ry;
    @(posedge clk);
    model();
    #2;
    n_run++;
    if (status !== exp_w) begin
      n_fail++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, exp_w);
    end
    exp_ry = !(busy && !susp);
    n_run++;
    if (ry !== exp_ry) begin
      n_fail++;
      $display("FAIL R2 ry_by actual=%b expected=%b", ry, exp_ry);
    end
  endtask

  task automatic rd(input int hold);
    strobe = 1;
    for (int i = 0; i < hold; i++) cyc();
    strobe = 0;
    cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, strobe activity ignored
    strobe = 1; arr = 16'hBEEF;
    for (int i = 0; i < 3; i++) cyc();
    strobe = 0;
    cyc();
    rst_ni = 1;
    cyc();
    // R9: idle reads pass array data
    for (int i = 0; i < 4; i++) begin
      arr = 16'h1234 * (i + 1) ^ 16'h5A5A;
      rd(1 + i);
    end
    // R3/R5/R8/R10: program, varying target bit, long strobe holds
    op = 0; busy = 1; sel = '0;
    for (int i = 0; i < 6; i++) begin
      tgt = i[0]; exc = (i == 4); tmo = 1;
      arr = 16'hFFFF;
      rd((i % 3) + 1);
      arr = 16'h0F0F;
      cyc();
    end
    // R4/R6/R7: erase, chosen and unchosen sectors, timer and out-of-range index
    op = 1; sel = 11'b100_0010_0101; tmo = 0; exc = 0;
    for (int i = 0; i < 16; i++) begin
      sec = SW'(i);
      tmo = (i > 5);
      exc = (i == 13);
      rd(1 + (i % 2));
    end
    // R11/R9: suspend, chosen and unchosen sectors; rise in the same step as susp
    sec = 0; susp = 1; strobe = 1; cyc(); strobe = 0; cyc();
    for (int i = 0; i < 8; i++) begin
      sec = SW'(i);
      arr = 16'hA000 + 16'(i);
      rd(1);
    end
    // resume, then busy falls with a rise in the same step
    susp = 0; sec = 2;
    rd(1); rd(2);
    busy = 0; arr = 16'hC3C3; strobe = 1; cyc(); strobe = 0; cyc();
    rd(1);
    // program then toggles hold while idle
    arr = 16'h7E7E; rd(3);
    op = 0; busy = 1; tgt = 1; rd(1); rd(1);
    busy = 0; rd(1);
    for (int i = 0; i < 3; i++) cyc();
    finish_run();
  end
endmodule